// File: doc/BRIEF.md
# General-Purpose I/O Port with Alternate Output Takeover

This block is an 8-bit general-purpose I/O port on a simple host register bus. Each pin has a direction bit and an output data bit, and the host writes both. The host reads back the direction bits, the data bits and the live pin levels through three separate registers. Each pin can also drive in open-drain style instead of push-pull. Each pin can be handed to an alternate signal, such as a chip-select line, which then replaces the GPIO data as the pin's output source.

The pad appears as three vectors: output enable, output value and input value. Both pad outputs are registered. The incoming pin levels pass through a two-flop synchroniser before the host can read them.

Register offsets:

| Offset | Register | Access |
|---|---|---|
| 0 | direction | write-only |
| 1 | data | write-only |
| 2 | direction readback | read-only |
| 3 | data readback | read-only |
| 4 | pin readback | read-only |
| 5 | open-drain mode | read/write |
| 6 | alternate select | read/write |

Offsets 0, 1 and 7 read as zero. Read data is registered and appears one cycle after the read strobe. Bit n of every register belongs to pin n.

Top module: `gpio_alt_port`

## Requirements
- R1: A synchronous active-high reset clears the direction, data, open-drain and alternate-select bits. After reset, pad_oe and pad_out are all zero and readbacks at offsets 2, 3, 5 and 6 return zero.
- R2: Pin n is driven only when its direction bit (offset 0) is 1 or its alternate-select bit is 1. A direction bit of 0 with no alternate selected leaves pad_oe[n] at 0.
- R3: For a pin in push-pull mode (open-drain bit 0), pad_out[n] equals the pin's source bit. The source bit is the data bit (offset 1), or alt_in[n] when the pin's alternate-select bit is 1.
- R4: A read strobe returns, on bus_rdata in the following cycle, the direction bits at offset 2, the data bits at offset 3, the open-drain bits at offset 5 and the alternate-select bits at offset 6. bus_rdata is zero in any cycle not preceded by a read strobe, and offsets 0, 1 and 7 read as zero.
- R5: A read at offset 4 returns the pad_in levels through a two-flop synchroniser, whatever the direction bits are. With the read strobe counted as one cycle after a pad_in change, a read issued in that same cycle or the next one returns the old level. A read issued two cycles after the change returns the new level.
- R6: For a pin in open-drain mode (open-drain bit 1 at offset 5), pad_out[n] is 0. pad_oe[n] is 1 only when the pin is driven and its source bit is 0, so the pin is never driven high.
- R7: Setting alternate-select bit n (offset 6) makes alt_in[n] the pin's source in place of the data bit, and enables the pin even when its direction bit is 0.
- R8: Writes to offsets 2, 3 and 4 change no register.
- R9: When a write and a read hit the same offset in one cycle, the read returns the value held before the write, and the write takes effect.
- R10: pad_oe and pad_out are registered. A change on alt_in or in a register reaches the pad one clock edge after it is seen by the logic, and does not reach the pad earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| alt_in | input | 8 | Alternate signals, bit n for pin n |
| pad_in | input | 8 | Pin levels from the pad |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |

## Verification
Two functions can fall in the same cycle: a host write to a register and a host read of that same register. The bench provokes this by raising the write and read strobes together at the open-drain offset, with a value different from the one stored. The read data must show the stored value. A second read must show the new value, and the new value must also appear in the open-drain behaviour at the pad. A second pair of simultaneous events is an alt_in change arriving while the pin is under alternate control. The bench judges it by sampling pad_out before the next edge and again after it.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA    = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_DIR_RB  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_DATA_RB = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_PIN_RB  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_ODRAIN  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_ALTSEL  = 3'd6;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_alt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  od_q,
  output logic [WIDTH-1:0]  alt_q
);
  logic [WIDTH-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      od_q   <= '0;
      alt_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DIR:    dir_q  <= bus_wdata;
        OFS_DATA:   data_q <= bus_wdata;
        OFS_ODRAIN: od_q   <= bus_wdata;
        OFS_ALTSEL: alt_q  <= bus_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DIR_RB:  rd_mux = dir_q;
      OFS_DATA_RB: rd_mux = data_q;
      OFS_PIN_RB:  rd_mux = pin_sync;
      OFS_ODRAIN:  rd_mux = od_q;
      OFS_ALTSEL:  rd_mux = alt_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic dir_bit,
  input  logic data_bit,
  input  logic od_bit,
  input  logic alt_bit,
  input  logic alt_sig,
  output logic oe_q,
  output logic out_q
);
  logic src;
  logic drive;

  assign src   = alt_bit ? alt_sig : data_bit;
  assign drive = dir_bit | alt_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      oe_q  <= drive & (od_bit ? ~src : 1'b1);
      out_q <= src & ~od_bit;
    end
  end
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
  import gpio_alt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  alt_in,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] od_q;
  logic [WIDTH-1:0] alt_q;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  gpio_regfile #(.WIDTH(WIDTH)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .od_q      (od_q),
    .alt_q     (alt_q)
  );

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    gpio_pin_drive i_drive (
      .clk      (clk),
      .rst      (rst),
      .dir_bit  (dir_q[n]),
      .data_bit (data_q[n]),
      .od_bit   (od_q[n]),
      .alt_bit  (alt_q[n]),
      .alt_sig  (alt_in[n]),
      .oe_q     (pad_oe[n]),
      .out_q    (pad_out[n])
    );
  end
endmodule

// File: rtl/gpio_alt_port_chk.sv
module gpio_alt_port_chk
  import gpio_alt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  data_q,
  input logic [WIDTH-1:0]  od_q,
  input logic [WIDTH-1:0]  alt_q,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out
);
  // R1
  reset_clears_pads_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0));

  // R2
  undriven_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pad_oe & ~($past(dir_q) | $past(alt_q))) == '0));

  // R6
  od_never_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pad_out & $past(od_q)) == '0));

  // R8
  readonly_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == OFS_DIR_RB || bus_addr == OFS_DATA_RB || bus_addr == OFS_PIN_RB))
    |=> ($stable(dir_q) && $stable(data_q) && $stable(od_q) && $stable(alt_q)));

  // R4
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind gpio_alt_port gpio_alt_port_chk #(.WIDTH(WIDTH)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .dir_q     (dir_q),
  .data_q    (data_q),
  .od_q      (od_q),
  .alt_q     (alt_q),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out)
);

// File: tb/test_gpio_alt_port.sv
module test_gpio_alt_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] alt_in = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  gpio_alt_port i_gpio_alt_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .alt_in(alt_in), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // {dir, data, od, alt, alt_in, expected oe, expected out}
  localparam logic [55:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5},
    {8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF},
    {8'hFF, 8'h3C, 8'hFF, 8'h00, 8'h00, 8'hC3, 8'h00},
    {8'h00, 8'h00, 8'h00, 8'hF0, 8'hAA, 8'hF0, 8'hA0},
    {8'h0F, 8'h05, 8'h0F, 8'h30, 8'h10, 8'h3A, 8'h10},
    {8'h81, 8'h80, 8'h00, 8'h00, 8'hFF, 8'h81, 8'h80}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    bus_read(3'd2, rv); check("R1 dir rb", rv, 8'h00);
    bus_read(3'd3, rv); check("R1 data rb", rv, 8'h00);
    bus_read(3'd5, rv); check("R1 od rb", rv, 8'h00);
    bus_read(3'd6, rv); check("R1 alt rb", rv, 8'h00);

    // table of pad vectors: R2 R3 R6 R7
    for (int i = 0; i < 6; i++) begin
      bus_write(3'd0, VEC[i][55:48]);
      bus_write(3'd1, VEC[i][47:40]);
      bus_write(3'd5, VEC[i][39:32]);
      bus_write(3'd6, VEC[i][31:24]);
      alt_in = VEC[i][23:16];
      @(negedge clk);
      check("R2/R6/R7 pad_oe", pad_oe, VEC[i][15:8]);
      check("R3/R6/R7 pad_out", pad_out, VEC[i][7:0]);
    end

    // R4 readbacks and zero offsets
    bus_write(3'd0, 8'h5C);
    bus_write(3'd1, 8'h93);
    bus_read(3'd2, rv); check("R4 dir rb", rv, 8'h5C);
    bus_read(3'd3, rv); check("R4 data rb", rv, 8'h93);
    bus_read(3'd0, rv); check("R4 offset0 zero", rv, 8'h00);
    bus_read(3'd1, rv); check("R4 offset1 zero", rv, 8'h00);
    bus_read(3'd7, rv); check("R4 offset7 zero", rv, 8'h00);
    @(negedge clk);
    check("R4 idle rdata", bus_rdata, 8'h00);

    // R8 writes to read-only offsets ignored
    bus_write(3'd2, 8'hFF);
    bus_write(3'd3, 8'h00);
    bus_write(3'd4, 8'hFF);
    bus_read(3'd2, rv); check("R8 dir kept", rv, 8'h5C);
    bus_read(3'd3, rv); check("R8 data kept", rv, 8'h93);

    // R5 pin readback latency, independent of direction
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    pad_in = 8'h6E;
    bus_read(3'd4, rv); check("R5 old at +0", rv, 8'h00);
    bus_read(3'd4, rv); check("R5 old at +1", rv, 8'h00);
    bus_read(3'd4, rv); check("R5 new at +2", rv, 8'h6E);

    // R9 simultaneous write and read of one offset
    bus_write(3'd6, 8'h00);
    bus_write(3'd0, 8'h01);
    bus_write(3'd1, 8'h01);
    bus_write(3'd5, 8'h00);
    bus_addr = 3'd5; bus_wdata = 8'h01; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 read sees old", bus_rdata, 8'h00);
    bus_read(3'd5, rv); check("R9 write landed", rv, 8'h01);
    check("R9 od pin released", pad_oe[0] ? 8'h01 : 8'h00, 8'h00);

    // R10 registered alternate path
    bus_write(3'd5, 8'h00);
    bus_write(3'd0, 8'h00);
    alt_in = 8'h00;
    bus_write(3'd6, 8'h01);
    @(negedge clk);
    check("R10 alt low", pad_out & 8'h01, 8'h00);
    alt_in = 8'h01;
    #1;
    check("R10 no early change", pad_out & 8'h01, 8'h00);
    @(negedge clk);
    check("R10 after edge", pad_out & 8'h01, 8'h01);
    check("R7 driven with dir 0", pad_oe & 8'h01, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule